// File: doc/BRIEF.md
# Capture-Delay Calibration Search

This block searches, without software involvement, for a capture-delay setting at which a synchronisation input is sampled reliably. It programs a target device with a 5-bit delay tap and a 4-bit setup/hold validation-window size through a write request/acknowledge handshake. For each setting it clears the device's sticky sampling-error flag, waits a programmable number of clock cycles, and then reads the per-channel error vector through a read request/valid handshake. Only the bit that belongs to the configured channel is used.

The search begins with the narrowest window. It tries delays in a zig-zag pattern around a seed. Each success makes the passing delay the new seed and moves on to a wider window. When a window yields no passing delay, the window is pulled back by one step plus a safety margin. That final pair is applied, the error flag is cleared, and after one more settle interval the result is announced with a one-cycle done pulse. If even the narrowest window has no passing delay, the done pulse comes with a failure flag.

Top module: `capdly_search`

## Requirements
- R1: After reset, `busy`, `done`, `wr_req` and `rd_req` are all low.
- R2: A `start` pulse while idle latches `seed` and begins at window 0. The first write carries delay = seed and window = 0. A `start` pulse while `busy` is high is ignored, as is any change of `seed` during the run.
- R3: For window w, candidate index i runs over 0 .. (31 − 2·w) − 1. Its delay is seed + (i>>1) when i is even and seed − (i>>1) when i is odd. This gives the order seed, seed, seed+1, seed−1, seed+2, and so on.
- R4: A candidate delay below 0 or above 31 is skipped. No write and no read are issued for it.
- R5: Each test issues a settings write (`wr_clear`=0, carrying delay and window), then a clear write (`wr_clear`=1). It waits at least `SETTLE` cycles after the clear is acknowledged and then reads. The outcome is bit (`chan` − 4) of `rd_err`, where 1 means error.
- R6: `wr_req` stays high with stable `wr_delay`, `wr_window` and `wr_clear` until `wr_ack` arrives. `rd_req` stays high until `rd_valid` arrives. The two requests are never high together.
- R7: A passing candidate becomes the new seed, and the search continues at window w+1 from index 0.
- R8: If no candidate passes at a window w > 0, the final window is max(0, w − 2). The seed and this window are written, the flag is cleared, and after a settle interval `done` rises with `fail`=0, `result_delay`=seed and `result_window`=final window.
- R9: If no candidate passes at window 0, `done` rises with `fail`=1.
- R10: If a candidate passes at window 15, the same roll-back is applied from window 15, and the reported window is 13.
- R11: `done` is a single-cycle pulse, and `busy` is low again in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (ignored while busy) |
| seed | input | 5 | Initial delay around which the scan starts |
| chan | input | 3 | Channel number; error bit index is chan − 4 |
| wr_req | output | 1 | Register write request |
| wr_clear | output | 1 | 1: clear sticky error flag; 0: apply delay/window |
| wr_delay | output | 5 | Delay tap to apply |
| wr_window | output | 4 | Validation window to apply |
| wr_ack | input | 1 | Write acknowledge |
| rd_req | output | 1 | Error-status read request |
| rd_err | input | 4 | Per-channel error bits, valid with rd_valid |
| rd_valid | input | 1 | Read data valid |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | No valid delay at window 0 (valid with done) |
| result_delay | output | 5 | Chosen delay (valid with done) |
| result_window | output | 4 | Chosen window (valid with done) |

## Verification
The hardest paths to reach are the two extremes. One is the run in which every window up to 15 keeps passing, so the search ends by rolling back from the top. The other is the run in which the zig-zag pushes past the edges of the tap range and has to skip candidates. The bench models the target as a diamond of good settings: a centre delay and a maximum window, where the good delays narrow by one tap on each side for every step of window. It sweeps seeds at both edges and in the middle against centres at both edges and in the middle. Diamonds that are empty, a single point, or wider than the window range then drive the search into the failure exit, the ordinary roll-back and the roll-back from 15. In every run, the full sequence of applied settings is compared with an arithmetic model of the scan order.

// File: rtl/capdly_search.sv
module capdly_search #(
  parameter int DW      = 5,
  parameter int WW      = 4,
  parameter int SETTLE  = 25000,
  parameter int MARGIN  = 1,
  parameter int NCH     = 4,
  parameter int CH_BASE = 4,
  parameter int CW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] seed,
  input  logic [CW-1:0] chan,
  output logic          wr_req,
  output logic          wr_clear,
  output logic [DW-1:0] wr_delay,
  output logic [WW-1:0] wr_window,
  input  logic          wr_ack,
  output logic          rd_req,
  input  logic [NCH-1:0] rd_err,
  input  logic          rd_valid,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [DW-1:0] result_delay,
  output logic [WW-1:0] result_window
);
  localparam int DMAX = (1 << DW) - 1;
  localparam int WMAX = (1 << WW) - 1;
  localparam int CNTW = $clog2(SETTLE + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CAND, S_SET, S_CLR, S_WAIT, S_READ, S_FSET, S_FCLR, S_FWAIT
  } st_t;

  st_t           st;
  logic [DW-1:0] seed_r, cand_r;
  logic [WW-1:0] win;
  logic [DW:0]   idx;
  logic [CNTW-1:0] cnt;

  logic [DW:0]   limit;
  logic [DW-1:0] off;
  logic [DW+1:0] sum;
  logic          in_range;
  logic [WW-1:0] back;
  logic          err;

  assign limit    = (DW+1)'(DMAX) - (DW+1)'(32'(win) << 1);
  assign off      = idx[DW:1];
  assign sum      = {2'b00, seed_r} + (idx[0] ? -{2'b00, off} : {2'b00, off});
  assign in_range = (sum[DW+1:DW] == 2'b00);
  assign back     = (win > WW'(MARGIN)) ? win - WW'(MARGIN + 1) : '0;

  always_comb begin
    err = 1'b0;
    for (int k = 0; k < NCH; k++)
      if (chan == CW'(CH_BASE + k)) err = rd_err[k];
  end

  assign wr_req    = (st == S_SET) || (st == S_CLR) || (st == S_FSET) || (st == S_FCLR);
  assign wr_clear  = (st == S_CLR) || (st == S_FCLR);
  assign wr_delay  = cand_r;
  assign wr_window = win;
  assign rd_req    = (st == S_READ);
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      seed_r        <= '0;
      cand_r        <= '0;
      win           <= '0;
      idx           <= '0;
      cnt           <= '0;
      done          <= 1'b0;
      fail          <= 1'b0;
      result_delay  <= '0;
      result_window <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          seed_r <= seed;
          win    <= '0;
          idx    <= '0;
          st     <= S_CAND;
        end
        S_CAND: begin
          if (idx >= limit) begin
            if (win == '0) begin
              done <= 1'b1;
              fail <= 1'b1;
              st   <= S_IDLE;
            end else begin
              win    <= back;
              cand_r <= seed_r;
              st     <= S_FSET;
            end
          end else if (!in_range) begin
            idx <= idx + 1'b1;
          end else begin
            cand_r <= sum[DW-1:0];
            st     <= S_SET;
          end
        end
        S_SET: if (wr_ack) st <= S_CLR;
        S_CLR: if (wr_ack) begin
          cnt <= '0;
          st  <= S_WAIT;
        end
        S_WAIT: begin
          if (cnt == CNTW'(SETTLE - 1)) st <= S_READ;
          else cnt <= cnt + 1'b1;
        end
        S_READ: if (rd_valid) begin
          if (!err) begin
            seed_r <= cand_r;
            idx    <= '0;
            if (win == WW'(WMAX)) begin
              win <= back;
              st  <= S_FSET;
            end else begin
              win <= win + 1'b1;
              st  <= S_CAND;
            end
          end else begin
            idx <= idx + 1'b1;
            st  <= S_CAND;
          end
        end
        S_FSET: if (wr_ack) st <= S_FCLR;
        S_FCLR: if (wr_ack) begin
          cnt <= '0;
          st  <= S_FWAIT;
        end
        S_FWAIT: begin
          if (cnt == CNTW'(SETTLE - 1)) begin
            done          <= 1'b1;
            fail          <= 1'b0;
            result_delay  <= cand_r;
            result_window <= win;
            st            <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req && rd_req));

  a_r6_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req && $stable(wr_delay) && $stable(wr_window) && $stable(wr_clear));

  a_r6_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid |=> rd_req);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r8_margin: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fail |-> result_window <= WW'(WMAX - 1 - MARGIN));

  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);
endmodule

// File: tb/capdly_search_bench.sv
module capdly_search_bench;
  localparam int SET  = 6;
  localparam int CHAN = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [4:0] seed = '0;
  logic [2:0] chan = 3'(CHAN);
  logic       wr_req, wr_clear, wr_ack = 1'b0;
  logic [4:0] wr_delay;
  logic [3:0] wr_window;
  logic       rd_req, rd_valid = 1'b0;
  logic [3:0] rd_err = '0;
  logic       busy, done, fail;
  logic [4:0] result_delay;
  logic [3:0] result_window;

  always #2 clk = ~clk;

  capdly_search #(.SETTLE(SET)) u_capdly_search (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .chan(chan),
    .wr_req(wr_req), .wr_clear(wr_clear), .wr_delay(wr_delay), .wr_window(wr_window),
    .wr_ack(wr_ack), .rd_req(rd_req), .rd_err(rd_err), .rd_valid(rd_valid),
    .busy(busy), .done(done), .fail(fail),
    .result_delay(result_delay), .result_window(result_window)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int sc_c, sc_wm;
  int cur_d, cur_w;
  int act_d[0:1023], act_w[0:1023], n_set, n_clr;
  int exp_d[0:1023], exp_w[0:1023], n_exp;
  int settle_bad, order_bad, pulse_bad, clr_cyc;
  bit got_done, g_fail, prev_done;
  int g_d, g_w;
  bit last_set;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic bit good(input int d, input int w);
    return (sc_wm >= w) && (d >= sc_c - (sc_wm - w)) && (d <= sc_c + (sc_wm - w));
  endfunction

  // scan-order model: returns expected fail, delay, window and list of applied settings
  task automatic model(input int s0, output bit efail, output int ed, output int ew);
    int s;
    s = s0; n_exp = 0; efail = 0; ed = 0; ew = 0;
    for (int w = 0; w < 16; w++) begin
      bit found;
      found = 0;
      for (int i = 0; i < 31 - 2*w; i++) begin
        int d;
        d = (i & 1) ? s - (i >> 1) : s + (i >> 1);
        if (d < 0 || d > 31) continue;
        exp_d[n_exp] = d; exp_w[n_exp] = w; n_exp++;
        if (good(d, w)) begin s = d; found = 1; break; end
      end
      if (found && w < 15) continue;
      if (!found && w == 0) begin efail = 1; return; end
      ew = (w >= 2) ? w - 2 : 0;
      ed = s;
      exp_d[n_exp] = ed; exp_w[n_exp] = ew; n_exp++;
      return;
    end
  endtask

  // target device model
  initial forever begin
    @(negedge clk);
    cyc++;
    if (prev_done && done) pulse_bad++;
    prev_done = done;
    if (done) begin
      got_done = 1; g_fail = fail; g_d = result_delay; g_w = result_window;
    end
    if (wr_req && rd_req) order_bad++;
    if (wr_ack) wr_ack = 1'b0;
    else if (wr_req) begin
      wr_ack = 1'b1;
      if (!wr_clear) begin
        if (last_set) order_bad++;
        if (n_set < 1024) begin act_d[n_set] = wr_delay; act_w[n_set] = wr_window; end
        n_set++; cur_d = wr_delay; cur_w = wr_window; last_set = 1;
      end else begin
        if (!last_set) order_bad++;
        n_clr++; clr_cyc = cyc; last_set = 0;
      end
    end
    if (rd_valid) rd_valid = 1'b0;
    else if (rd_req) begin
      bit e;
      if (cyc - clr_cyc < SET) settle_bad++;
      e = !good(cur_d, cur_w);
      rd_err = {4{!e}};
      rd_err[CHAN-4] = e;
      rd_valid = 1'b1;
    end
  end

  task automatic finish_all();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    wait (cyc > 190000);
    chk(0, "watchdog", cyc, 190000);
    finish_all();
  end

  task automatic run(input int s0, input int c, input int wm);
    bit efail; int ed, ew, first_bad;
    sc_c = c; sc_wm = wm;
    model(s0, efail, ed, ew);
    n_set = 0; n_clr = 0; settle_bad = 0; order_bad = 0; pulse_bad = 0;
    got_done = 0; last_set = 0;
    @(negedge clk); seed = 5'(s0); start = 1'b1;
    @(negedge clk); start = 1'b0;
    // R2: start and seed change during a run have no effect
    repeat (3) @(negedge clk);
    seed = ~5'(s0); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!got_done) @(negedge clk);
    @(negedge clk);
    chk(!busy, "R11 busy low after done", busy, 0);
    chk(pulse_bad == 0, "R11 done pulse width", pulse_bad, 0);
    chk(g_fail == efail, efail ? "R9 fail flag" : "R8 fail flag", g_fail, efail);
    if (!efail) begin
      chk(g_d == ed, (wm >= 15) ? "R10 result delay" : "R8 result delay", g_d, ed);
      chk(g_w == ew, (wm >= 15) ? "R10 result window" : "R8 result window", g_w, ew);
    end
    chk(n_set == n_exp, "R4 applied setting count", n_set, n_exp);
    first_bad = -1;
    for (int k = 0; k < n_exp && k < n_set; k++)
      if (first_bad < 0 && (act_d[k] != exp_d[k] || act_w[k] != exp_w[k])) first_bad = k;
    chk(first_bad < 0, "R3 R7 scan order (index of first mismatch)", first_bad, -1);
    if (n_set > 0) chk(act_d[0] == s0 && act_w[0] == 0, "R2 first setting", act_d[0], s0);
    chk(n_clr == n_set, "R5 clear per setting", n_clr, n_set);
    chk(settle_bad == 0, "R5 settle before read", settle_bad, 0);
    chk(order_bad == 0, "R6 write/read ordering", order_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !wr_req && !rd_req, "R1 reset state",
        {busy, done, wr_req, rd_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !wr_req && !rd_req, "R1 idle after reset", {busy, wr_req, rd_req}, 0);
    foreach (seedv[i]) ;
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 3; b++)
        for (int m = 0; m < 4; m++) begin
          int sv[5] = '{0, 15, 31, 3, 28};
          int cv[3] = '{2, 15, 29};
          int wv[4] = '{-1, 0, 2, 20};
          run(sv[a], cv[b], wv[m]);
        end
    finish_all();
  end

  int seedv[1];
endmodule